// File: doc/BRIEF.md
# Power-of-Two Sample Averager

This block sits in the result path of an analog-to-digital converter, between the conversion stream and the sample FIFO. It adds up consecutive conversions from one input and hands downstream a single averaged word per group. The group size is a power of two, chosen by a 3-bit log2 shift code. Code 0 makes the block a transparent, registered pass-through. Every word it emits is the full average of a complete group, so output throughput is the input rate divided by the group size. For example, a group of four turns 250 k samples per second into 62.5 k.

One setting covers every sequence that feeds the converter. A flush strobe, raised on a channel change, restarts the group. A change of the shift code also restarts it. In both cases no output word ever mixes samples from two channels or from two settings.

Top module: `pow2_sample_averager`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `out_valid` is 0 and `out_sample` is 0.
- R2: With shift code 0, each accepted sample is output unchanged. `out_valid` is 1 in the cycle after the sample is presented with `in_valid` high.
- R3: With shift code k in 1..6, one word is output per 2^k accepted samples. Its value is floor(sum of those samples / 2^k).
- R4: `out_valid` is high for exactly one cycle. That cycle comes right after the cycle in which the last sample of the group was accepted. Cycles with `in_valid` low do not advance the group.
- R5: The accumulator holds a full group without overflow. 64 samples of 1023 at code 6 give 1023.
- R6: In a cycle with `flush` high, the partial group is discarded, and so is any sample presented in that cycle. `out_valid` is 0 in the next cycle.
- R7: A cycle in which `shift_code` differs from its value in the previous cycle acts as a flush (R6). The new code governs from that cycle on. During reset the code is captured, so a code held steady through reset causes no restart.
- R8: Shift code 7 behaves exactly like shift code 6 (groups of 64).
- R9: `out_sample` keeps its last value in every cycle where `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Conversion result valid this cycle |
| in_sample | input | 10 | Conversion result |
| shift_code | input | 3 | log2 of the group size; 0 is bypass, 7 is treated as 6 |
| flush | input | 1 | Restart the group and drop this cycle's sample |
| out_valid | output | 1 | One-cycle pulse: averaged word available |
| out_sample | output | 10 | Averaged word, held between pulses |

## Verification
The hardest conditions to reach are a restart landing in the middle of a group, and a restart landing in the same cycle as a valid sample. The stimulus reaches them in three ways. It fills part of a group and then raises flush together with a valid sample. It changes the shift code while a group is partly filled. It then finishes a fresh group, which exposes any leftover sum in the averaged value. Every code from 0 to 7 is swept, with idle gaps between samples. Full-scale runs of 64 maximum values exercise the top of the accumulator.

// File: rtl/avg_pkg.sv
package avg_pkg;
    localparam int SAMPLE_W  = 10;
    localparam int CODE_W    = 3;
    localparam int MAX_SHIFT = 6;
    localparam int ACC_W     = SAMPLE_W + MAX_SHIFT;
    localparam int CNT_W     = MAX_SHIFT;

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [ACC_W-1:0]    acc_t;
    typedef logic [CNT_W-1:0]    cnt_t;
    typedef logic [CODE_W-1:0]   code_t;

    typedef struct packed {
        logic    valid;
        sample_t data;
    } avg_word_t;

    // Codes above the largest supported shift saturate to it.
    function automatic code_t clamp_shift(input code_t code);
        return (code > code_t'(MAX_SHIFT)) ? code_t'(MAX_SHIFT) : code;
    endfunction

    // Index of the last sample of a group of 2^shift.
    function automatic cnt_t last_index(input code_t shift);
        return ~({CNT_W{1'b1}} << shift);
    endfunction
endpackage

// File: rtl/avg_restart_ctrl.sv
module avg_restart_ctrl
    import avg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  code_t shift_code,
    input  logic  flush,
    output logic  restart,
    output code_t eff_shift
);
    code_t code_q;

    // The code is sampled during reset as well, so a steady code causes no restart.
    always_ff @(posedge clk) begin
        code_q <= shift_code;
    end

    always_comb begin
        restart   = flush || (shift_code != code_q);
        eff_shift = clamp_shift(shift_code);
    end
endmodule

// File: rtl/avg_accum.sv
module avg_accum
    import avg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    restart,
    input  logic    in_valid,
    input  sample_t in_sample,
    input  code_t   shift,
    output logic    done,
    output acc_t    sum_full
);
    acc_t acc_q;
    cnt_t cnt_q;
    logic take;

    always_comb begin
        take     = in_valid && !restart;
        sum_full = acc_q + acc_t'(in_sample);
        done     = take && (cnt_q == last_index(shift));
    end

    always_ff @(posedge clk) begin
        if (rst || restart || done) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (take) begin
            acc_q <= sum_full;
            cnt_q <= cnt_q + cnt_t'(1);
        end
    end
endmodule

// File: rtl/avg_emit.sv
module avg_emit
    import avg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      done,
    input  acc_t      sum_full,
    input  code_t     shift,
    output avg_word_t word
);
    sample_t cand [MAX_SHIFT+1];

    // The division by 2^s is a fixed bit slice per shift value.
    for (genvar s = 0; s <= MAX_SHIFT; s++) begin : g_slice
        assign cand[s] = sum_full[s +: SAMPLE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
        end else begin
            word.valid <= done;
            if (done) begin
                word.data <= cand[shift];
            end
        end
    end
endmodule

// File: rtl/pow2_sample_averager.sv
module pow2_sample_averager
    import avg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic [CODE_W-1:0]   shift_code,
    input  logic                flush,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_sample
);
    logic      restart;
    code_t     eff_shift;
    logic      done;
    acc_t      sum_full;
    avg_word_t word;

    avg_restart_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .shift_code (shift_code),
        .flush      (flush),
        .restart    (restart),
        .eff_shift  (eff_shift)
    );

    avg_accum u_acc (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .shift     (eff_shift),
        .done      (done),
        .sum_full  (sum_full)
    );

    avg_emit u_emit (
        .clk      (clk),
        .rst      (rst),
        .done     (done),
        .sum_full (sum_full),
        .shift    (eff_shift),
        .word     (word)
    );

    assign out_valid  = word.valid;
    assign out_sample = word.data;
endmodule

// File: rtl/avg_chk.sv
module avg_chk
    import avg_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [SAMPLE_W-1:0] in_sample,
    input logic [CODE_W-1:0]   shift_code,
    input logic                flush,
    input logic                out_valid,
    input logic [SAMPLE_W-1:0] out_sample
);
    code_t code_seen;

    always_ff @(posedge clk) begin
        code_seen <= shift_code;
    end

    // R4
    pulse_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid && !flush));

    // R2
    bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !flush && shift_code == '0 && code_seen == '0)
        |=> (out_valid && out_sample == $past(in_sample)));

    // R6
    flush_no_emit_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> !out_valid);

    // R7
    change_no_emit_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_code != code_seen) |=> !out_valid);

    // R9
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_sample));
endmodule

bind pow2_sample_averager avg_chk u_chk (.*);

// File: tb/pow2_sample_averager_tb.sv
module pow2_sample_averager_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [9:0] in_sample = '0;
    logic [2:0] shift_code = '0;
    logic       flush = 1'b0;
    logic       out_valid;
    logic [9:0] out_sample;

    int n_cmp = 0;
    int n_bad = 0;
    string tag = "R1";

    // Bench model state, derived from the requirements
    int         m_sum = 0;
    int         m_cnt = 0;
    logic [2:0] m_code = '0;
    logic       e_valid = 1'b0;
    logic [9:0] e_data = '0;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    pow2_sample_averager u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .shift_code(shift_code), .flush(flush),
        .out_valid(out_valid), .out_sample(out_sample)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [9:0] next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[9:0];
    endfunction

    // Drive one cycle, advance the model, and check the outputs after the edge.
    task automatic cyc(input logic v, input logic [9:0] s, input logic f, input logic [2:0] c);
        int eff;
        in_valid = v; in_sample = s; flush = f; shift_code = c;
        eff = (c > 3'd6) ? 6 : int'(c);
        e_valid = 1'b0;
        if (f || c != m_code) begin
            m_sum = 0; m_cnt = 0;
        end else if (v) begin
            m_sum += int'(s);
            m_cnt++;
            if (m_cnt == (1 << eff)) begin
                e_valid = 1'b1;
                e_data = 10'(m_sum >> eff);
                m_sum = 0; m_cnt = 0;
            end
        end
        m_code = c;
        @(negedge clk);
        check({tag, " valid"}, int'(out_valid), int'(e_valid));
        check({tag, " data"}, int'(out_sample), int'(e_data));
    endtask

    initial begin
        @(negedge clk);
        check("R1 reset valid", int'(out_valid), 0);
        check("R1 reset data", int'(out_sample), 0);
        @(negedge clk);
        rst = 1'b0;
        m_code = shift_code;
        tag = "R1";
        cyc(1'b0, 10'd0, 1'b0, 3'd0);

        // R2 bypass sweep
        tag = "R2";
        cyc(1'b1, 10'd0, 1'b0, 3'd0);
        cyc(1'b1, 10'd1023, 1'b0, 3'd0);
        for (int i = 0; i < 60; i++) cyc((i % 4) != 3, next_rand(), 1'b0, 3'd0);

        // R3/R4 for every code 1..6, with idle gaps
        for (int k = 1; k <= 6; k++) begin
            tag = "R3";
            cyc(1'b0, 10'd0, 1'b0, 3'(k));
            for (int i = 0; i < 3 * (1 << k) * 4 / 3 + 3; i++)
                cyc((i % 3) != 2, next_rand(), 1'b0, 3'(k));
            tag = "R4";
            for (int i = 0; i < 2 * (1 << k); i++) cyc(1'b1, next_rand(), 1'b0, 3'(k));
            for (int i = 0; i < 5; i++) cyc(1'b0, next_rand(), 1'b0, 3'(k));
        end

        // R5 full-scale group at code 6, and all zero
        tag = "R5";
        for (int i = 0; i < 64; i++) cyc(1'b1, 10'd1023, 1'b0, 3'd6);
        for (int i = 0; i < 64; i++) cyc(1'b1, 10'd0, 1'b0, 3'd6);
        for (int i = 0; i < 64; i++) cyc(1'b1, 10'd1023, 1'b0, 3'd6);

        // R6 flush mid-group with a valid sample in the flush cycle
        tag = "R6";
        for (int i = 0; i < 5; i++) cyc(1'b1, 10'd1000, 1'b0, 3'd3);
        cyc(1'b1, 10'd1023, 1'b1, 3'd3);
        for (int i = 0; i < 8; i++) cyc(1'b1, 10'd8, 1'b0, 3'd3);
        cyc(1'b1, 10'd3, 1'b0, 3'd2);
        cyc(1'b1, 10'd5, 1'b1, 3'd2);
        for (int i = 0; i < 4; i++) cyc(1'b1, 10'd16 + 10'(i), 1'b0, 3'd2);

        // R7 code change mid-group
        tag = "R7";
        for (int i = 0; i < 3; i++) cyc(1'b1, 10'd900, 1'b0, 3'd2);
        cyc(1'b1, 10'd900, 1'b0, 3'd1);
        cyc(1'b1, 10'd10, 1'b0, 3'd1);
        cyc(1'b1, 10'd20, 1'b0, 3'd1);
        for (int i = 0; i < 7; i++) cyc(1'b1, 10'd500, 1'b0, 3'd4);
        cyc(1'b1, 10'd40, 1'b0, 3'd0);
        cyc(1'b1, 10'd41, 1'b0, 3'd0);

        // R8 code 7 groups of 64
        tag = "R8";
        cyc(1'b0, 10'd0, 1'b0, 3'd7);
        for (int i = 0; i < 200; i++) cyc((i % 5) != 0, next_rand(), 1'b0, 3'd7);

        // R9 long idle stretch, output must hold
        tag = "R9";
        for (int i = 0; i < 20; i++) cyc(1'b0, next_rand(), 1'b0, 3'd7);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule